// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit virtual address into a physical page number by reading a two-level page table from memory. A requester offers a single translation with the address, the kind of access (instruction fetch, data load or data store), the current privilege, an override bit and override mode for data accesses, the root table page, a translation-enable bit and two permission modifiers. The block answers one or more cycles later with a single-cycle `done` pulse that carries either a fault or a physical page number and read, write and execute permissions.

Page table entries are fetched through a read port that holds its request until the memory answers. When a leaf entry is usable but its accessed bit, or its dirty bit for a store, is still clear, the block updates it through a compare-and-swap port. If that swap finds the entry already changed, the walk starts again from the root. Only one translation is handled at a time. Requests offered while the block is busy are dropped.

Top module: `pt_walker`

## Requirements
- R1: A request is taken when `req_valid` is high and `busy` is low. From the cycle after it is taken, `busy` stays high until the cycle in which `done` pulses for exactly one cycle with `busy` low. Requests offered while `busy` is high have no effect on the result. Read and swap requests are only raised while busy, and never together.
- R2: The effective mode is the override mode when the privilege is machine (code 3), the access is not a fetch and the override bit is set. Otherwise it is the privilege. Privilege codes are user 0, supervisor 1, machine 3. Access codes are fetch 0, load 1, store 2.
- R3: With effective mode machine, or translation disabled, the result is no fault, page number equal to the virtual address bits 31:12, and all three permissions granted. No memory is read.
- R4: Entries are 32 bits. The first read is at root_ppn×4096 + VA[31:22]×4. A pointer entry at the first level gives the second read at its PPN×4096 + VA[21:12]×4. The read request and address are held until the read answer arrives. Entry bits: V=0, R=1, W=2, X=3, U=4, A=6, D=7, PPN=31:10.
- R5: An entry with V clear faults. An entry with V set and R, W, X all clear is a pointer. A pointer at the second level faults.
- R6: A leaf with W set and R clear (W alone, or W with X) faults.
- R7: A leaf with U set faults if the effective mode is not user and either the user-access bit is clear or the access is a fetch. A leaf with U clear faults if the effective mode is not supervisor.
- R8: A leaf found at the first level whose PPN bits 9:0 are not all zero faults.
- R9: A load needs R, or X with the executable-readable bit set. A store needs W. A fetch needs X.
- R10: A passing leaf gets A set, and D too for a store, through a swap that compares against the value read. No swap is issued when those bits are already set.
- R11: A swap that reports failure restarts the walk from the root entry. The result then follows the entry values read by the new walk.
- R12: On success, a first-level leaf yields {PPN[21:10], VA[21:12]} and a second-level leaf yields its PPN. Read is R or (X and executable-readable). Execute is X. Write is W when the access is a store or D was set. On a fault, the page number and all permissions are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Translation request |
| req_vaddr | input | 32 | Virtual address |
| req_access | input | 2 | Access kind: fetch 0, load 1, store 2 |
| req_priv | input | 2 | Current privilege: user 0, supervisor 1, machine 3 |
| req_override_en | input | 1 | Use override mode for data accesses in machine mode |
| req_override_mode | input | 2 | Mode used when the override applies |
| root_ppn | input | 22 | Page number of the first-level table |
| xlate_on | input | 1 | Translation enable |
| exec_readable | input | 1 | Loads may use execute-only pages |
| user_page_ok | input | 1 | Supervisor data access to user pages allowed |
| busy | output | 1 | A walk is in progress |
| done | output | 1 | Single-cycle result strobe |
| fault | output | 1 | Translation failed |
| pa_ppn | output | 22 | Physical page number |
| perm_r | output | 1 | Read granted |
| perm_w | output | 1 | Write granted |
| perm_x | output | 1 | Execute granted |
| mem_rd_req | output | 1 | Entry read request, held until answered |
| mem_rd_addr | output | 34 | Entry read byte address |
| mem_rd_valid | input | 1 | Read answer strobe |
| mem_rd_data | input | 32 | Entry value read |
| mem_cas_req | output | 1 | Compare-and-swap request, held until answered |
| mem_cas_addr | output | 34 | Entry byte address for the swap |
| mem_cas_cmp | output | 32 | Value the entry must still hold |
| mem_cas_new | output | 32 | Value to store |
| mem_cas_valid | input | 1 | Swap answer strobe |
| mem_cas_ok | input | 1 | Swap took place |

## Verification
The assertions watch the handshake on every cycle. They check that `done` is a one-cycle pulse at the moment `busy` falls, that memory requests only appear while busy and never both at once, that a pending read keeps its word-aligned address, that every swap sets the accessed bit and changes the entry, and that a faulting result carries no page number or permission. Whether a particular entry is accepted or rejected, the merged superpage number, the permission flags and the restart after a lost swap depend on table contents. The bench's scenarios show these by comparing each result against a behavioural walk over the same memory image, and by counting reads and swaps.

// File: rtl/pt_walker_pkg.sv
package pt_walker_pkg;

  typedef enum logic [1:0] {
    ACC_FETCH = 2'd0,
    ACC_LOAD  = 2'd1,
    ACC_STORE = 2'd2
  } acc_e;

  localparam logic [1:0] MODE_USER = 2'd0;
  localparam logic [1:0] MODE_SUP  = 2'd1;
  localparam logic [1:0] MODE_MACH = 2'd3;

  localparam int BIT_V = 0;
  localparam int BIT_R = 1;
  localparam int BIT_W = 2;
  localparam int BIT_X = 3;
  localparam int BIT_U = 4;
  localparam int BIT_A = 6;
  localparam int BIT_D = 7;
  localparam int PPN_LSB = 10;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_READ,
    ST_SWAP,
    ST_FIN
  } walk_st_e;

endpackage

// File: rtl/pt_entry_addr.sv
module pt_entry_addr #(
  parameter int OFF_W  = 12,
  parameter int IDX_W  = 10,
  parameter int LEVELS = 2,
  parameter int PPN_W  = 22,
  parameter int PTE_W  = 32,
  localparam int VPN_W  = IDX_W * LEVELS,
  localparam int PA_W   = PPN_W + OFF_W,
  localparam int LVL_W  = (LEVELS > 1) ? $clog2(LEVELS) : 1,
  localparam int PTE_LG = $clog2(PTE_W / 8)
) (
  input  logic [PPN_W-1:0] base_ppn,
  input  logic [VPN_W-1:0] vpn,
  input  logic [LVL_W-1:0] level,
  output logic [PA_W-1:0]  entry_addr
);

  logic [IDX_W-1:0] idx;

  always_comb begin
    idx = vpn[int'(level) * IDX_W +: IDX_W];
    entry_addr = {base_ppn, {OFF_W{1'b0}}} + (PA_W'(idx) << PTE_LG);
  end

endmodule

// File: rtl/pt_leaf_check.sv
module pt_leaf_check
  import pt_walker_pkg::*;
#(
  parameter int IDX_W  = 10,
  parameter int LEVELS = 2,
  parameter int PPN_W  = 22,
  parameter int PTE_W  = 32,
  localparam int VPN_W = IDX_W * LEVELS,
  localparam int LVL_W = (LEVELS > 1) ? $clog2(LEVELS) : 1
) (
  input  logic [PTE_W-1:0] pte,
  input  logic [LVL_W-1:0] level,
  input  acc_e             acc,
  input  logic [1:0]       mode,
  input  logic             exec_rd,
  input  logic             user_ok,
  input  logic [VPN_W-1:0] vpn,
  output logic             leaf_ok,
  output logic             need_upd,
  output logic [PTE_W-1:0] new_pte,
  output logic [PPN_W-1:0] out_ppn,
  output logic             pr,
  output logic             pw,
  output logic             px
);

  logic             r, w, x, u, d;
  logic [PPN_W-1:0] ppn, low_mask;
  logic             rsvd, user_bad, mis, acc_bad;

  always_comb begin
    r   = pte[BIT_R];
    w   = pte[BIT_W];
    x   = pte[BIT_X];
    u   = pte[BIT_U];
    d   = pte[BIT_D];
    ppn = pte[PPN_LSB +: PPN_W];
    low_mask = ~({PPN_W{1'b1}} << (int'(level) * IDX_W));

    rsvd = w && !r;
    if (u) user_bad = (mode != MODE_USER) && (!user_ok || acc == ACC_FETCH);
    else   user_bad = (mode != MODE_SUP);
    mis = (ppn & low_mask) != '0;

    unique case (acc)
      ACC_LOAD:  acc_bad = !(r || (x && exec_rd));
      ACC_STORE: acc_bad = !w;
      ACC_FETCH: acc_bad = !x;
      default:   acc_bad = 1'b1;
    endcase

    leaf_ok  = !(rsvd || user_bad || mis || acc_bad);
    new_pte  = pte;
    new_pte[BIT_A] = 1'b1;
    if (acc == ACC_STORE) new_pte[BIT_D] = 1'b1;
    need_upd = new_pte != pte;

    out_ppn = ppn | (PPN_W'(vpn) & low_mask);
    pr = r || (x && exec_rd);
    px = x;
    pw = w && (acc == ACC_STORE || d);
  end

endmodule

// File: rtl/pt_walker.sv
module pt_walker
  import pt_walker_pkg::*;
#(
  parameter int VA_W   = 32,
  parameter int OFF_W  = 12,
  parameter int IDX_W  = 10,
  parameter int LEVELS = 2,
  parameter int PPN_W  = 22,
  parameter int PTE_W  = 32,
  localparam int VPN_W = IDX_W * LEVELS,
  localparam int PA_W  = PPN_W + OFF_W,
  localparam int LVL_W = (LEVELS > 1) ? $clog2(LEVELS) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_valid,
  input  logic [VA_W-1:0]  req_vaddr,
  input  logic [1:0]       req_access,
  input  logic [1:0]       req_priv,
  input  logic             req_override_en,
  input  logic [1:0]       req_override_mode,
  input  logic [PPN_W-1:0] root_ppn,
  input  logic             xlate_on,
  input  logic             exec_readable,
  input  logic             user_page_ok,
  output logic             busy,
  output logic             done,
  output logic             fault,
  output logic [PPN_W-1:0] pa_ppn,
  output logic             perm_r,
  output logic             perm_w,
  output logic             perm_x,
  output logic             mem_rd_req,
  output logic [PA_W-1:0]  mem_rd_addr,
  input  logic             mem_rd_valid,
  input  logic [PTE_W-1:0] mem_rd_data,
  output logic             mem_cas_req,
  output logic [PA_W-1:0]  mem_cas_addr,
  output logic [PTE_W-1:0] mem_cas_cmp,
  output logic [PTE_W-1:0] mem_cas_new,
  input  logic             mem_cas_valid,
  input  logic             mem_cas_ok
);

  localparam logic [LVL_W-1:0] TOP_LVL = LVL_W'(LEVELS - 1);

  walk_st_e         st_q;
  logic [VPN_W-1:0] vpn_q;
  acc_e             acc_q;
  logic [1:0]       mode_q;
  logic             xrd_q, uok_q;
  logic [PPN_W-1:0] root_q, base_q;
  logic [LVL_W-1:0] lvl_q;
  logic [PTE_W-1:0] old_q, upd_q;

  logic             pend_fault, pend_r, pend_w, pend_x;
  logic [PPN_W-1:0] pend_ppn;

  logic [PA_W-1:0]  entry_addr;
  logic [1:0]       eff_mode;
  logic             pass_thru;

  logic             lf_ok, lf_upd, lf_r, lf_w, lf_x;
  logic [PTE_W-1:0] lf_new;
  logic [PPN_W-1:0] lf_ppn;

  always_comb begin
    if (req_priv == MODE_MACH && acc_e'(req_access) != ACC_FETCH && req_override_en)
      eff_mode = req_override_mode;
    else
      eff_mode = req_priv;
    pass_thru = (eff_mode == MODE_MACH) || !xlate_on;
  end

  pt_entry_addr #(
    .OFF_W(OFF_W), .IDX_W(IDX_W), .LEVELS(LEVELS), .PPN_W(PPN_W), .PTE_W(PTE_W)
  ) u_addr (
    .base_ppn  (base_q),
    .vpn       (vpn_q),
    .level     (lvl_q),
    .entry_addr(entry_addr)
  );

  pt_leaf_check #(
    .IDX_W(IDX_W), .LEVELS(LEVELS), .PPN_W(PPN_W), .PTE_W(PTE_W)
  ) u_leaf (
    .pte     (mem_rd_data),
    .level   (lvl_q),
    .acc     (acc_q),
    .mode    (mode_q),
    .exec_rd (xrd_q),
    .user_ok (uok_q),
    .vpn     (vpn_q),
    .leaf_ok (lf_ok),
    .need_upd(lf_upd),
    .new_pte (lf_new),
    .out_ppn (lf_ppn),
    .pr      (lf_r),
    .pw      (lf_w),
    .px      (lf_x)
  );

  assign mem_rd_req   = (st_q == ST_READ);
  assign mem_rd_addr  = entry_addr;
  assign mem_cas_req  = (st_q == ST_SWAP);
  assign mem_cas_addr = entry_addr;
  assign mem_cas_cmp  = old_q;
  assign mem_cas_new  = upd_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q       <= ST_IDLE;
      busy       <= 1'b0;
      done       <= 1'b0;
      fault      <= 1'b0;
      pa_ppn     <= '0;
      perm_r     <= 1'b0;
      perm_w     <= 1'b0;
      perm_x     <= 1'b0;
      vpn_q      <= '0;
      acc_q      <= ACC_FETCH;
      mode_q     <= MODE_USER;
      xrd_q      <= 1'b0;
      uok_q      <= 1'b0;
      root_q     <= '0;
      base_q     <= '0;
      lvl_q      <= '0;
      old_q      <= '0;
      upd_q      <= '0;
      pend_fault <= 1'b0;
      pend_ppn   <= '0;
      pend_r     <= 1'b0;
      pend_w     <= 1'b0;
      pend_x     <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (st_q)
        ST_IDLE: begin
          if (req_valid) begin
            busy   <= 1'b1;
            vpn_q  <= req_vaddr[OFF_W +: VPN_W];
            acc_q  <= acc_e'(req_access);
            mode_q <= eff_mode;
            xrd_q  <= exec_readable;
            uok_q  <= user_page_ok;
            root_q <= root_ppn;
            base_q <= root_ppn;
            lvl_q  <= TOP_LVL;
            if (pass_thru) begin
              pend_fault <= 1'b0;
              pend_ppn   <= PPN_W'(req_vaddr >> OFF_W);
              pend_r     <= 1'b1;
              pend_w     <= 1'b1;
              pend_x     <= 1'b1;
              st_q       <= ST_FIN;
            end else begin
              st_q <= ST_READ;
            end
          end
        end
        ST_READ: begin
          if (mem_rd_valid) begin
            if (!mem_rd_data[BIT_V]) begin
              pend_fault <= 1'b1;
              st_q       <= ST_FIN;
            end else if (!mem_rd_data[BIT_R] && !mem_rd_data[BIT_W] && !mem_rd_data[BIT_X]) begin
              if (lvl_q == '0) begin
                pend_fault <= 1'b1;
                st_q       <= ST_FIN;
              end else begin
                base_q <= mem_rd_data[PPN_LSB +: PPN_W];
                lvl_q  <= lvl_q - 1'b1;
              end
            end else if (!lf_ok) begin
              pend_fault <= 1'b1;
              st_q       <= ST_FIN;
            end else begin
              pend_fault <= 1'b0;
              pend_ppn   <= lf_ppn;
              pend_r     <= lf_r;
              pend_w     <= lf_w;
              pend_x     <= lf_x;
              old_q      <= mem_rd_data;
              upd_q      <= lf_new;
              st_q       <= lf_upd ? ST_SWAP : ST_FIN;
            end
          end
        end
        ST_SWAP: begin
          if (mem_cas_valid) begin
            if (mem_cas_ok) begin
              st_q <= ST_FIN;
            end else begin
              base_q <= root_q;
              lvl_q  <= TOP_LVL;
              st_q   <= ST_READ;
            end
          end
        end
        ST_FIN: begin
          busy  <= 1'b0;
          done  <= 1'b1;
          fault <= pend_fault;
          if (pend_fault) begin
            pa_ppn <= '0;
            perm_r <= 1'b0;
            perm_w <= 1'b0;
            perm_x <= 1'b0;
          end else begin
            pa_ppn <= pend_ppn;
            perm_r <= pend_r;
            perm_w <= pend_w;
            perm_x <= pend_x;
          end
          st_q <= ST_IDLE;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/pt_walker_chk.sv
module pt_walker_chk #(
  parameter int PPN_W = 22,
  parameter int PA_W  = 34,
  parameter int PTE_W = 32
) (
  input logic             clk,
  input logic             rst,
  input logic             busy,
  input logic             done,
  input logic             fault,
  input logic [PPN_W-1:0] pa_ppn,
  input logic             perm_r,
  input logic             perm_w,
  input logic             perm_x,
  input logic             mem_rd_req,
  input logic [PA_W-1:0]  mem_rd_addr,
  input logic             mem_rd_valid,
  input logic             mem_cas_req,
  input logic [PTE_W-1:0] mem_cas_cmp,
  input logic [PTE_W-1:0] mem_cas_new
);

  assert_done_idle_R1: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);

  assert_busy_end_R1: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> done);

  assert_done_pulse_R1: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  assert_one_port_R1: assert property (@(posedge clk) disable iff (rst)
    $onehot0({mem_rd_req, mem_cas_req}));

  assert_mem_busy_R1: assert property (@(posedge clk) disable iff (rst)
    (mem_rd_req || mem_cas_req) |-> busy);

  assert_rd_hold_R4: assert property (@(posedge clk) disable iff (rst)
    (mem_rd_req && !mem_rd_valid) |=> (mem_rd_req && $stable(mem_rd_addr)));

  assert_rd_align_R4: assert property (@(posedge clk) disable iff (rst)
    mem_rd_req |-> (mem_rd_addr[1:0] == 2'b00));

  assert_swap_sets_a_R10: assert property (@(posedge clk) disable iff (rst)
    mem_cas_req |-> (mem_cas_new[6] && (mem_cas_new != mem_cas_cmp)));

  assert_fault_zero_R12: assert property (@(posedge clk) disable iff (rst)
    (done && fault) |-> (!perm_r && !perm_w && !perm_x && pa_ppn == '0));

endmodule

bind pt_walker pt_walker_chk #(.PPN_W(22), .PA_W(34), .PTE_W(32)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .busy        (busy),
  .done        (done),
  .fault       (fault),
  .pa_ppn      (pa_ppn),
  .perm_r      (perm_r),
  .perm_w      (perm_w),
  .perm_x      (perm_x),
  .mem_rd_req  (mem_rd_req),
  .mem_rd_addr (mem_rd_addr),
  .mem_rd_valid(mem_rd_valid),
  .mem_cas_req (mem_cas_req),
  .mem_cas_cmp (mem_cas_cmp),
  .mem_cas_new (mem_cas_new)
);

// File: tb/pt_walker_test.sv
module pt_walker_test;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic [31:0] req_vaddr = '0;
  logic [1:0]  req_access = '0, req_priv = '0, req_override_mode = '0;
  logic        req_override_en = 1'b0;
  logic [21:0] root_ppn = 22'h00100;
  logic        xlate_on = 1'b0, exec_readable = 1'b0, user_page_ok = 1'b0;
  logic        busy, done, fault, perm_r, perm_w, perm_x;
  logic [21:0] pa_ppn;
  logic        mem_rd_req, mem_cas_req;
  logic [33:0] mem_rd_addr, mem_cas_addr;
  logic        mem_rd_valid = 1'b0, mem_cas_valid = 1'b0, mem_cas_ok = 1'b0;
  logic [31:0] mem_rd_data = '0;
  logic [31:0] mem_cas_cmp, mem_cas_new;

  int checks = 0;
  int errors = 0;
  int rd_count = 0;
  int cas_count = 0;
  bit race_arm = 1'b0;
  logic [31:0] race_val = '0;
  logic [31:0] pmem [logic [33:0]];

  always #5 clk = ~clk;

  pt_walker uut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_vaddr(req_vaddr),
    .req_access(req_access), .req_priv(req_priv), .req_override_en(req_override_en),
    .req_override_mode(req_override_mode), .root_ppn(root_ppn), .xlate_on(xlate_on),
    .exec_readable(exec_readable), .user_page_ok(user_page_ok),
    .busy(busy), .done(done), .fault(fault), .pa_ppn(pa_ppn),
    .perm_r(perm_r), .perm_w(perm_w), .perm_x(perm_x),
    .mem_rd_req(mem_rd_req), .mem_rd_addr(mem_rd_addr), .mem_rd_valid(mem_rd_valid),
    .mem_rd_data(mem_rd_data), .mem_cas_req(mem_cas_req), .mem_cas_addr(mem_cas_addr),
    .mem_cas_cmp(mem_cas_cmp), .mem_cas_new(mem_cas_new), .mem_cas_valid(mem_cas_valid),
    .mem_cas_ok(mem_cas_ok)
  );

  function automatic logic [31:0] rdm(input logic [33:0] a);
    if (pmem.exists(a)) return pmem[a];
    return 32'h0;
  endfunction

  // memory model: answers one cycle after a request is seen
  always @(negedge clk) begin
    if (mem_rd_valid) mem_rd_valid = 1'b0;
    else if (mem_rd_req) begin
      mem_rd_data  = rdm(mem_rd_addr);
      mem_rd_valid = 1'b1;
      rd_count++;
    end
    if (mem_cas_valid) mem_cas_valid = 1'b0;
    else if (mem_cas_req) begin
      cas_count++;
      if (race_arm) begin
        pmem[mem_cas_addr] = race_val;
        race_arm = 1'b0;
        mem_cas_ok = 1'b0;
      end else if (rdm(mem_cas_addr) == mem_cas_cmp) begin
        pmem[mem_cas_addr] = mem_cas_new;
        mem_cas_ok = 1'b1;
      end else mem_cas_ok = 1'b0;
      mem_cas_valid = 1'b1;
    end
  end

  task automatic check(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // behavioural walk over the bench memory
  task automatic ref_walk(input logic [31:0] va, input int acc, input int prv, input bit ovr,
                          input int ovm, input bit en, input bit xr, input bit uok,
                          output bit flt, output logic [21:0] ppn, output bit r, output bit w, output bit x);
    int mode;
    logic [33:0] base, ea;
    logic [31:0] e;
    bit pr, pw, px, pu, pd;
    mode = (prv == 3 && acc != 0 && ovr) ? ovm : prv;
    flt = 1; ppn = 0; r = 0; w = 0; x = 0;
    if (mode == 3 || !en) begin
      flt = 0; ppn = 22'(va >> 12); r = 1; w = 1; x = 1;
      return;
    end
    base = {root_ppn, 12'h000};
    for (int lvl = 1; lvl >= 0; lvl--) begin
      ea = base + 34'((lvl == 1 ? va[31:22] : va[21:12])) * 4;
      e  = rdm(ea);
      if (!e[0]) return;
      pr = e[1]; pw = e[2]; px = e[3]; pu = e[4]; pd = e[7];
      if (!pr && !pw && !px) begin
        base = {e[31:10], 12'h000};
        continue;
      end
      if (pw && !pr) return;
      if (pu && mode != 0 && (!uok || acc == 0)) return;
      if (!pu && mode != 1) return;
      if (lvl == 1 && e[19:10] != 0) return;
      if (acc == 1 && !(pr || (px && xr))) return;
      if (acc == 2 && !pw) return;
      if (acc == 0 && !px) return;
      flt = 0;
      ppn = (lvl == 1) ? {e[31:20], va[21:12]} : e[31:10];
      r = pr || (px && xr);
      x = px;
      w = pw && (acc == 2 || pd);
      return;
    end
  endtask

  // issue one request; keep_extra holds a different request high while busy
  task automatic run(input string req, input logic [31:0] va, input int acc, input int prv,
                     input bit ovr, input int ovm, input bit en, input bit xr, input bit uok,
                     input bit keep_extra);
    bit flt, er, ew, ex, busy_ok;
    logic [21:0] eppn;
    int n;
    @(negedge clk);
    req_vaddr = va; req_access = 2'(acc); req_priv = 2'(prv);
    req_override_en = ovr; req_override_mode = 2'(ovm);
    xlate_on = en; exec_readable = xr; user_page_ok = uok;
    req_valid = 1'b1;
    @(negedge clk);
    if (keep_extra) begin
      req_vaddr = 32'h0040_6000; req_access = 2'd2;
      @(negedge clk);
      @(negedge clk);
    end
    req_valid = 1'b0;
    busy_ok = 1'b1;
    n = 0;
    while (!done && n < 200) begin
      if (!busy) busy_ok = 1'b0;
      @(negedge clk);
      n++;
    end
    check("R1", {req, " done seen"}, 64'(done), 64'd1);
    check("R1", {req, " busy held until done"}, 64'(busy_ok), 64'd1);
    check("R1", {req, " busy low at done"}, 64'(busy), 64'd0);
    ref_walk(va, acc, prv, ovr, ovm, en, xr, uok, flt, eppn, er, ew, ex);
    check(req, {req, " fault"}, 64'(fault), 64'(flt));
    check(req, {req, " ppn"}, 64'(pa_ppn), 64'(eppn));
    check(req, {req, " perms rwx"}, 64'({perm_r, perm_w, perm_x}), 64'({er, ew, ex}));
    @(negedge clk);
    check("R1", {req, " done single cycle"}, 64'(done), 64'd0);
  endtask

  localparam logic [33:0] L1 = 34'h0_0010_0000;
  localparam logic [33:0] L0 = 34'h0_0020_0000;

  initial begin
    int rd0, cas0;
    // R4 layout: first level at root 0x100, pointer at index 1 to table 0x200
    pmem[L1 + 4]  = (32'h200 << 10) | 32'h01;
    pmem[L1 + 8]  = (32'h400 << 10) | 32'h13;   // superpage, aligned
    pmem[L1 + 12] = (32'h401 << 10) | 32'h13;   // superpage, misaligned
    pmem[L0 + 4]  = (32'hAAA << 10) | 32'h17;   // V R W U
    pmem[L0 + 8]  = (32'hBBB << 10) | 32'h19;   // V X U
    pmem[L0 + 12] = (32'hCC0 << 10) | 32'h15;   // V W U, reserved
    pmem[L0 + 16] = (32'hCCC << 10) | 32'h03;   // V R, supervisor
    pmem[L0 + 20] = (32'hDDD << 10) | 32'hD7;   // V R W U A D
    pmem[L0 + 24] = 32'h0;                      // invalid
    pmem[L0 + 28] = (32'hEEE << 10) | 32'h19;   // V X U
    pmem[L0 + 32] = (32'h300 << 10) | 32'h01;   // pointer at last level
    pmem[L0 + 36] = (32'h111 << 10) | 32'h13;   // race target

    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1", "reset busy", 64'(busy), 64'd0);
    check("R1", "reset done", 64'(done), 64'd0);
    check("R4", "reset read request", 64'(mem_rd_req), 64'd0);

    rd0 = rd_count;
    run("R3", 32'h1234_5678, 1, 3, 0, 0, 1, 0, 0, 0);
    run("R3", 32'h8765_4321, 2, 0, 0, 0, 0, 0, 0, 0);
    check("R3", "no reads on pass-through", 64'(rd_count - rd0), 64'd0);

    cas0 = cas_count;
    run("R4", 32'h0040_1000, 1, 0, 0, 0, 1, 0, 0, 0);
    check("R10", "A set after load", 64'(pmem[L0 + 4][7:6]), 64'b01);
    run("R12", 32'h0040_1abc, 2, 0, 0, 0, 1, 0, 0, 0);
    check("R10", "D set after store", 64'(pmem[L0 + 4][7:6]), 64'b11);
    check("R10", "two swaps issued", 64'(cas_count - cas0), 64'd2);
    cas0 = cas_count;
    run("R10", 32'h0040_5000, 2, 0, 0, 0, 1, 0, 0, 0);
    check("R10", "no swap when A and D set", 64'(cas_count - cas0), 64'd0);

    run("R9", 32'h0040_2000, 0, 0, 0, 0, 1, 0, 0, 0);
    run("R9", 32'h0040_2000, 2, 0, 0, 0, 1, 0, 0, 0);
    run("R7", 32'h0040_1000, 1, 1, 0, 0, 1, 0, 0, 0);
    run("R7", 32'h0040_1000, 1, 1, 0, 0, 1, 0, 1, 0);
    run("R7", 32'h0040_2000, 0, 1, 0, 0, 1, 0, 1, 0);
    run("R7", 32'h0040_4000, 1, 0, 0, 0, 1, 0, 0, 0);
    run("R7", 32'h0040_4000, 1, 1, 0, 0, 1, 0, 0, 0);
    run("R6", 32'h0040_3000, 2, 0, 0, 0, 1, 0, 0, 0);
    run("R5", 32'h0040_6000, 1, 0, 0, 0, 1, 0, 0, 0);
    run("R5", 32'h0040_8000, 1, 0, 0, 0, 1, 0, 0, 0);
    run("R5", 32'h0100_0000, 1, 0, 0, 0, 1, 0, 0, 0);
    run("R9", 32'h0040_7000, 1, 0, 0, 0, 1, 0, 0, 0);
    run("R9", 32'h0040_7000, 1, 0, 0, 0, 1, 1, 0, 0);
    run("R12", 32'h0080_5123, 1, 0, 0, 0, 1, 0, 0, 0);
    check("R12", "superpage ppn", 64'(pa_ppn), 64'h405);
    run("R8", 32'h00C0_5000, 1, 0, 0, 0, 1, 0, 0, 0);
    check("R8", "misaligned superpage faults", 64'(fault), 64'd1);
    run("R2", 32'h0040_1000, 1, 3, 1, 0, 1, 0, 0, 0);
    check("R2", "override translates to user page", 64'(pa_ppn), 64'hAAA);
    run("R2", 32'h0040_1000, 0, 3, 1, 0, 1, 0, 0, 0);
    check("R2", "fetch ignores override", 64'(pa_ppn), 64'h00401);

    race_val = (32'h222 << 10) | 32'h53;
    race_arm = 1'b1;
    rd0 = rd_count; cas0 = cas_count;
    run("R11", 32'h0040_9000, 1, 0, 0, 0, 1, 0, 0, 0);
    check("R11", "ppn after restart", 64'(pa_ppn), 64'h222);
    check("R11", "reads after restart", 64'(rd_count - rd0), 64'd4);
    check("R11", "swaps after restart", 64'(cas_count - cas0), 64'd1);

    run("R1", 32'h0040_1000, 1, 0, 0, 0, 1, 0, 0, 1);
    check("R1", "request while busy ignored", 64'(pa_ppn), 64'hAAA);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #1_500_000;
    errors++;
    $display("FAIL R1 watchdog actual hung expected finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule